// File: doc/BRIEF.md
# Multi-lane SPI read transfer sequencer

This block is the controller side of one multi-lane SPI read. It drives one active-low select line, a serial clock and up to eight data lanes. A transaction has up to four phases, always in this order: an instruction, an address, a run of dummy clock periods and a data receive phase. The instruction and the address can each be left out. A start strobe that is accepted latches the configuration and the instruction and address values. From then on the block steps through the phases. Each received frame is handed to the host side with a one-cycle valid strobe.

The serial clock runs at half the system clock. Each serial period is one system cycle low followed by one system cycle high. Lanes change only as the serial clock falls, and incoming lanes are captured as it rises. The lane format selects one, two, four or eight lanes for data. The transfer mode decides whether the instruction and the address also use the wide lanes or stay on a single lane. With no instruction and no address, a single start strobe with a non-zero dummy count launches a pure read.

Top module: `mlspi_rd_seq`

## Requirements
- R1: While reset is asserted and afterwards until a start is accepted: ss_n_o=1, sclk_o=0, busy_o=0, oe_n_o all ones, rx_valid_o=0.
- R2: lane_fmt_i selects the data lanes. 00 means single line: transmit on lane 0, receive on rxd_i[1]. 01 means lanes 1:0, 10 means lanes 3:0 and 11 means lanes 7:0.
- R3: xfer_mode_i sets the width of the command phases. 00 sends instruction and address on lane 0 only. 01 sends the instruction on lane 0 and the address on the data lanes. 10 and 11 send both on the data lanes.
- R4: inst_len_i 0/1/2/3 selects 0/4/8/16 instruction bits, taken from the low end of inst_i. Bits go out most significant first. Within each group of w lanes, lane w-1 carries the most significant bit. A final group that is not full is padded with zeros.
- R5: The address holds 4 × addr_len_i bits (0 means no address phase), taken from the low end of addr_i. It uses the same ordering and padding as R4.
- R6: The phases run instruction, address, dummy, data with no gap between them. Each serial period is 2 clock cycles, low then high, and the lanes change only when sclk falls. ss_n_o falls in the cycle after the start is accepted and stays low for exactly 2×(total periods) cycles.
- R7: The dummy phase lasts wait_i serial periods. No lane is driven during it.
- R8: oe_n_o is 0 on exactly the active lanes during the instruction and address phases, and all ones in every other phase.
- R9: In the data phase rxd_i is captured at the clock edge where sclk_o rises. The first group received is the most significant. When a frame of FRAME_BITS bits is complete, rx_valid_o pulses for one cycle with the frame on rx_data_o.
- R10: frames_i holds the number of frames minus one. ss_n_o returns high at the end of the serial period that carries the last group of the last frame.
- R11: A start with inst_len_i=0, addr_len_i=0 and wait_i=0 is refused and the block stays idle. With wait_i non-zero, the same start runs a dummy-then-data read.
- R12: busy_o is high from the cycle after acceptance until ss_n_o rises. A start while busy is ignored, and so is any configuration change made during the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_fmt_i | input | 2 | Data lane format |
| xfer_mode_i | input | 2 | Lane width for the instruction and address phases |
| inst_len_i | input | 2 | Instruction length code |
| addr_len_i | input | ACODE_W | Address length in nibbles |
| wait_i | input | WAIT_W | Dummy serial periods |
| frames_i | input | FCNT_W | Frames to receive, minus one |
| start_i | input | 1 | Start strobe |
| inst_i | input | 16 | Instruction value |
| addr_i | input | 4×(2^ACODE_W−1) | Address value |
| rxd_i | input | 8 | Incoming lane values |
| sclk_o | output | 1 | Serial clock |
| txd_o | output | 8 | Outgoing lane values |
| oe_n_o | output | 8 | Per-lane output enables, active low |
| ss_n_o | output | 1 | Slave select, active low |
| busy_o | output | 1 | Transaction in progress |
| rx_data_o | output | FRAME_BITS | Received frame |
| rx_valid_o | output | 1 | One-cycle strobe for rx_data_o |

## Verification
The bench uses the default parameters: 16-bit frames, an 8-bit frame count, a 5-bit dummy count and a 4-bit address code. With these values every frame is spread over several serial periods even at eight lanes, so frame assembly across groups is always exercised. The full 60-bit address and the padded 4-bit case are both reachable with eight lanes. A behavioural slave drives new lane values in every low half and records every high half. A scoreboard compares the frames against values predicted from the requirements.

// File: rtl/mlspi_pkg.sv
package mlspi_pkg;
    localparam int LANES  = 8;
    localparam int INST_W = 16;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_INST = 3'd1,
        PH_ADDR = 3'd2,
        PH_WAIT = 3'd3,
        PH_DATA = 3'd4
    } phase_e;
endpackage

// File: rtl/mlspi_cfg_dec.sv
module mlspi_cfg_dec #(
    parameter int FRAME_BITS = 16,
    parameter int WAIT_W     = 5,
    parameter int ACODE_W    = 4,
    parameter int CNT_W      = 7,
    parameter int BW         = 7
) (
    input  logic [1:0]         fmt_i,
    input  logic [1:0]         mode_i,
    input  logic [1:0]         ilen_i,
    input  logic [ACODE_W-1:0] alen_i,
    input  logic [WAIT_W-1:0]  wcyc_i,
    output logic [1:0]         lw_i_o,
    output logic [1:0]         lw_a_o,
    output logic [1:0]         lw_d_o,
    output logic [BW-1:0]      i_bits_o,
    output logic [BW-1:0]      a_bits_o,
    output logic [CNT_W-1:0]   i_slots_o,
    output logic [CNT_W-1:0]   a_slots_o,
    output logic [CNT_W-1:0]   d_slots_o,
    output logic               legal_o
);
    int wi;
    int wa;

    always_comb begin
        // data width follows the format code directly (log2 of lanes)
        lw_d_o = fmt_i;
        lw_i_o = mode_i[1] ? fmt_i : 2'd0;
        lw_a_o = (mode_i != 2'b00) ? fmt_i : 2'd0;
        case (ilen_i)
            2'd0:    i_bits_o = BW'(0);
            2'd1:    i_bits_o = BW'(4);
            2'd2:    i_bits_o = BW'(8);
            default: i_bits_o = BW'(16);
        endcase
        a_bits_o  = BW'({alen_i, 2'b00});
        wi        = 1 << lw_i_o;
        wa        = 1 << lw_a_o;
        i_slots_o = CNT_W'((int'(i_bits_o) + wi - 1) >> lw_i_o);
        a_slots_o = CNT_W'((int'(a_bits_o) + wa - 1) >> lw_a_o);
        d_slots_o = CNT_W'(FRAME_BITS >> lw_d_o);
        legal_o   = (ilen_i != 2'd0) || (alen_i != '0) || (wcyc_i != '0);
    end
endmodule

// File: rtl/mlspi_lane_drv.sv
module mlspi_lane_drv #(
    parameter int LANES = 8
) (
    input  logic             drive_i,
    input  logic [1:0]       lw_i,
    input  logic [LANES-1:0] grp_i,
    output logic [LANES-1:0] txd_o,
    output logic [LANES-1:0] oe_n_o
);
    int width;
    always_comb width = 1 << lw_i;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic act;
        assign act       = drive_i && (k < width);
        assign txd_o[k]  = act ? grp_i[(LANES - width + k) % LANES] : 1'b0;
        assign oe_n_o[k] = ~act;
    end
endmodule

// File: rtl/mlspi_rd_seq.sv
module mlspi_rd_seq
    import mlspi_pkg::*;
#(
    parameter int FRAME_BITS = 16,
    parameter int FCNT_W     = 8,
    parameter int WAIT_W     = 5,
    parameter int ACODE_W    = 4,
    localparam int ADDR_MAX  = 4 * ((1 << ACODE_W) - 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            lane_fmt_i,
    input  logic [1:0]            xfer_mode_i,
    input  logic [1:0]            inst_len_i,
    input  logic [ACODE_W-1:0]    addr_len_i,
    input  logic [WAIT_W-1:0]     wait_i,
    input  logic [FCNT_W-1:0]     frames_i,
    input  logic                  start_i,
    input  logic [INST_W-1:0]     inst_i,
    input  logic [ADDR_MAX-1:0]   addr_i,
    input  logic [LANES-1:0]      rxd_i,
    output logic                  sclk_o,
    output logic [LANES-1:0]      txd_o,
    output logic [LANES-1:0]      oe_n_o,
    output logic                  ss_n_o,
    output logic                  busy_o,
    output logic [FRAME_BITS-1:0] rx_data_o,
    output logic                  rx_valid_o
);
    localparam int CNT_W = $clog2(ADDR_MAX + INST_W + (1 << WAIT_W) + FRAME_BITS + 1);
    localparam int BW    = $clog2(ADDR_MAX + INST_W + 1);
    localparam int ASR_W = ((ADDR_MAX + LANES - 1) / LANES) * LANES;

    typedef struct packed {
        phase_e                ph;
        logic                  sclk;
        logic [CNT_W-1:0]      cnt;
        logic [FCNT_W-1:0]     frm;
        logic [INST_W-1:0]     isr;
        logic [ASR_W-1:0]      asr;
        logic [FRAME_BITS-1:0] rsr;
        logic                  rvalid;
        logic [FRAME_BITS-1:0] rdata;
        logic [1:0]            lw_i;
        logic [1:0]            lw_a;
        logic [1:0]            lw_d;
        logic                  has_a;
        logic [CNT_W-1:0]      a_slots;
        logic [WAIT_W-1:0]     wcyc;
        logic [CNT_W-1:0]      d_slots;
    } seq_t;

    seq_t cur_q, nx_d;

    logic [1:0]       c_lw_i, c_lw_a, c_lw_d;
    logic [BW-1:0]    c_i_bits, c_a_bits;
    logic [CNT_W-1:0] c_i_slots, c_a_slots, c_d_slots;
    logic             c_legal;

    mlspi_cfg_dec #(
        .FRAME_BITS(FRAME_BITS), .WAIT_W(WAIT_W), .ACODE_W(ACODE_W),
        .CNT_W(CNT_W), .BW(BW)
    ) u_cfg (
        .fmt_i(lane_fmt_i), .mode_i(xfer_mode_i), .ilen_i(inst_len_i),
        .alen_i(addr_len_i), .wcyc_i(wait_i),
        .lw_i_o(c_lw_i), .lw_a_o(c_lw_a), .lw_d_o(c_lw_d),
        .i_bits_o(c_i_bits), .a_bits_o(c_a_bits),
        .i_slots_o(c_i_slots), .a_slots_o(c_a_slots), .d_slots_o(c_d_slots),
        .legal_o(c_legal)
    );

    logic [FRAME_BITS-1:0] rx_new;

    always_comb begin
        case (cur_q.lw_d)
            2'd0:    rx_new = {cur_q.rsr[FRAME_BITS-2:0], rxd_i[1]};
            2'd1:    rx_new = {cur_q.rsr[FRAME_BITS-3:0], rxd_i[1:0]};
            2'd2:    rx_new = {cur_q.rsr[FRAME_BITS-5:0], rxd_i[3:0]};
            default: rx_new = {cur_q.rsr[FRAME_BITS-9:0], rxd_i[7:0]};
        endcase
    end

    always_comb begin
        nx_d        = cur_q;
        nx_d.rvalid = 1'b0;
        case (cur_q.ph)
            PH_IDLE: begin
                if (start_i && c_legal) begin
                    nx_d.lw_i    = c_lw_i;
                    nx_d.lw_a    = c_lw_a;
                    nx_d.lw_d    = c_lw_d;
                    nx_d.has_a   = (c_a_slots != '0);
                    nx_d.a_slots = c_a_slots;
                    nx_d.wcyc    = wait_i;
                    nx_d.d_slots = c_d_slots;
                    nx_d.frm     = frames_i;
                    nx_d.sclk    = 1'b0;
                    nx_d.isr     = inst_i << (INST_W - int'(c_i_bits));
                    nx_d.asr     = ASR_W'(addr_i) << (ASR_W - int'(c_a_bits));
                    if (c_i_slots != '0) begin
                        nx_d.ph  = PH_INST;
                        nx_d.cnt = c_i_slots - CNT_W'(1);
                    end else if (c_a_slots != '0) begin
                        nx_d.ph  = PH_ADDR;
                        nx_d.cnt = c_a_slots - CNT_W'(1);
                    end else if (wait_i != '0) begin
                        nx_d.ph  = PH_WAIT;
                        nx_d.cnt = CNT_W'(wait_i) - CNT_W'(1);
                    end else begin
                        nx_d.ph  = PH_DATA;
                        nx_d.cnt = c_d_slots - CNT_W'(1);
                    end
                end
            end
            default: begin
                if (!cur_q.sclk) begin
                    // rising serial edge: capture in the data phase
                    nx_d.sclk = 1'b1;
                    if (cur_q.ph == PH_DATA) begin
                        nx_d.rsr = rx_new;
                        if (cur_q.cnt == '0) begin
                            nx_d.rvalid = 1'b1;
                            nx_d.rdata  = rx_new;
                        end
                    end
                end else begin
                    // falling serial edge: advance lanes or phase
                    nx_d.sclk = 1'b0;
                    if (cur_q.cnt != '0) begin
                        nx_d.cnt = cur_q.cnt - CNT_W'(1);
                        if (cur_q.ph == PH_INST) nx_d.isr = cur_q.isr << (1 << cur_q.lw_i);
                        if (cur_q.ph == PH_ADDR) nx_d.asr = cur_q.asr << (1 << cur_q.lw_a);
                    end else begin
                        case (cur_q.ph)
                            PH_INST: begin
                                if (cur_q.has_a) begin
                                    nx_d.ph  = PH_ADDR;
                                    nx_d.cnt = cur_q.a_slots - CNT_W'(1);
                                end else if (cur_q.wcyc != '0) begin
                                    nx_d.ph  = PH_WAIT;
                                    nx_d.cnt = CNT_W'(cur_q.wcyc) - CNT_W'(1);
                                end else begin
                                    nx_d.ph  = PH_DATA;
                                    nx_d.cnt = cur_q.d_slots - CNT_W'(1);
                                end
                            end
                            PH_ADDR: begin
                                if (cur_q.wcyc != '0) begin
                                    nx_d.ph  = PH_WAIT;
                                    nx_d.cnt = CNT_W'(cur_q.wcyc) - CNT_W'(1);
                                end else begin
                                    nx_d.ph  = PH_DATA;
                                    nx_d.cnt = cur_q.d_slots - CNT_W'(1);
                                end
                            end
                            PH_WAIT: begin
                                nx_d.ph  = PH_DATA;
                                nx_d.cnt = cur_q.d_slots - CNT_W'(1);
                            end
                            default: begin
                                if (cur_q.frm == '0) begin
                                    nx_d.ph = PH_IDLE;
                                end else begin
                                    nx_d.frm = cur_q.frm - FCNT_W'(1);
                                    nx_d.cnt = cur_q.d_slots - CNT_W'(1);
                                end
                            end
                        endcase
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nx_d;
    end

    logic             drv_en;
    logic [1:0]       drv_lw;
    logic [LANES-1:0] drv_grp;

    always_comb begin
        drv_en  = (cur_q.ph == PH_INST) || (cur_q.ph == PH_ADDR);
        drv_lw  = (cur_q.ph == PH_INST) ? cur_q.lw_i : cur_q.lw_a;
        drv_grp = (cur_q.ph == PH_INST) ? cur_q.isr[INST_W-1 -: LANES]
                                        : cur_q.asr[ASR_W-1 -: LANES];
    end

    mlspi_lane_drv #(.LANES(LANES)) u_lanes (
        .drive_i(drv_en), .lw_i(drv_lw), .grp_i(drv_grp),
        .txd_o(txd_o), .oe_n_o(oe_n_o)
    );

    assign sclk_o     = cur_q.sclk;
    assign ss_n_o     = (cur_q.ph == PH_IDLE);
    assign busy_o     = (cur_q.ph != PH_IDLE);
    assign rx_data_o  = cur_q.rdata;
    assign rx_valid_o = cur_q.rvalid;

    p_sclk_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n_o |-> !sclk_o);
    p_tx_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> $stable(txd_o));
    p_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ss_n_o && !$past(ss_n_o)) |-> (sclk_o != $past(sclk_o)));
    p_oe_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_q.ph == PH_WAIT) || (cur_q.ph == PH_DATA)) |-> (oe_n_o == '1));
    p_valid_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> (sclk_o && !ss_n_o));
    p_reject_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_n_o && start_i && inst_len_i == 2'd0 && addr_len_i == '0 && wait_i == '0)
        |=> ss_n_o);
endmodule

// File: tb/mlspi_rd_seq_bench.sv
module mlspi_rd_seq_bench;
    localparam int FB = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fmt = '0, xm = '0, il = '0;
    logic [3:0]  al = '0;
    logic [4:0]  wc = '0;
    logic [7:0]  fc = '0;
    logic        start = 1'b0;
    logic [15:0] inst = '0;
    logic [59:0] addr = '0;
    logic [7:0]  rxd;
    logic        sclk, ss_n, busy, rx_valid;
    logic [7:0]  txd, oe_n;
    logic [FB-1:0] rx_data;

    always #10 clk = ~clk;

    mlspi_rd_seq u_mlspi_rd_seq (
        .clk(clk), .rst_n(rst_n), .lane_fmt_i(fmt), .xfer_mode_i(xm),
        .inst_len_i(il), .addr_len_i(al), .wait_i(wc), .frames_i(fc),
        .start_i(start), .inst_i(inst), .addr_i(addr), .rxd_i(rxd),
        .sclk_o(sclk), .txd_o(txd), .oe_n_o(oe_n), .ss_n_o(ss_n),
        .busy_o(busy), .rx_data_o(rx_data), .rx_valid_o(rx_valid)
    );

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    logic [7:0]    exp_tx[$], exp_msk[$], exp_oe[$], drv_q[$];
    logic [7:0]    rec_tx[$], rec_oe[$];
    logic [FB-1:0] sb_q[$];
    int            data_start = 0;
    int            nrise = 0;
    bit            cur_single = 1'b0;
    bit            prev_sclk = 1'b0;

    // slave model and scoreboard monitor, both acting at the falling clock
    initial begin
        logic [7:0]    lv;
        logic [FB-1:0] e;
        rxd = 8'h00;
        forever begin
            @(negedge clk);
            if (!ss_n) begin
                if (sclk && !prev_sclk) begin
                    rec_tx.push_back(txd);
                    rec_oe.push_back(oe_n);
                    nrise++;
                end
                if (!sclk) begin
                    if (nrise >= data_start && (nrise - data_start) < drv_q.size()) begin
                        lv  = drv_q[nrise - data_start];
                        rxd = cur_single ? {6'b0, lv[0], 1'b0} : lv;
                    end else begin
                        rxd = 8'hA5;
                    end
                end
            end
            prev_sclk = sclk;
            if (rx_valid) begin
                if (sb_q.size() == 0) chk(1'b0, "R9 unexpected frame", 64'(rx_data), 64'h0);
                else begin
                    e = sb_q.pop_front();
                    chk(rx_data == e, "R9 frame value", 64'(rx_data), 64'(e));
                end
            end
        end
    end

    task automatic add_field(input logic [127:0] val, input int bits, input int lw);
        int w, slots;
        logic [127:0] big;
        logic [7:0] g, m;
        w = 1 << lw;
        slots = (bits + w - 1) / w;
        big = val << (slots * w - bits);
        for (int s = 0; s < slots; s++) begin
            m = 8'((1 << w) - 1);
            g = 8'(big >> ((slots - 1 - s) * w)) & m;
            exp_tx.push_back(g);
            exp_msk.push_back(m);
            exp_oe.push_back(~m);
        end
    endtask

    task automatic run_xfer(input logic [1:0] f, input logic [1:0] x, input logic [1:0] i_l,
                            input logic [3:0] a_l, input logic [4:0] w_c, input logic [7:0] f_c,
                            input logic [15:0] iv, input logic [59:0] av, input int seed,
                            input bit poke, input string tag);
        int wd, lwi, lwa, ib, ab, spf, total, n_low;
        logic [FB-1:0] frame;
        logic [7:0] g, m;
        wd  = 1 << f;
        lwi = x[1] ? int'(f) : 0;
        lwa = (x != 2'b00) ? int'(f) : 0;
        ib  = (i_l == 0) ? 0 : (i_l == 1) ? 4 : (i_l == 2) ? 8 : 16;
        ab  = int'(a_l) * 4;
        exp_tx.delete(); exp_msk.delete(); exp_oe.delete(); drv_q.delete();
        rec_tx.delete(); rec_oe.delete(); sb_q.delete();
        nrise = 0;
        add_field(128'(iv) & ((128'd1 << ib) - 1), ib, lwi);
        add_field(128'(av) & ((128'd1 << ab) - 1), ab, lwa);
        for (int k = 0; k < int'(w_c); k++) begin
            exp_tx.push_back(8'h00); exp_msk.push_back(8'h00); exp_oe.push_back(8'hFF);
        end
        data_start = exp_tx.size();
        spf = FB / wd;
        m = 8'((1 << wd) - 1);
        for (int fr = 0; fr <= int'(f_c); fr++) begin
            frame = '0;
            for (int s = 0; s < spf; s++) begin
                g = 8'(fr * 53 + s * 29 + seed) & m;
                drv_q.push_back(g);
                exp_tx.push_back(8'h00); exp_msk.push_back(8'h00); exp_oe.push_back(8'hFF);
                frame = FB'((frame << wd) | FB'(g));
            end
            sb_q.push_back(frame);
        end
        total = exp_tx.size();
        cur_single = (f == 2'b00);
        @(negedge clk);
        fmt = f; xm = x; il = i_l; al = a_l; wc = w_c; fc = f_c; inst = iv; addr = av;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(ss_n == 1'b0 && busy == 1'b1, {"R12 R6 accept ", tag}, 64'({ss_n, busy}), 64'h1);
        n_low = 1;
        forever begin
            @(negedge clk);
            if (poke && n_low == 6) begin
                start = 1'b1; fmt = ~f; il = 2'd3; al = 4'd2; wc = 5'd1; fc = 8'd9;
            end else begin
                start = 1'b0;
            end
            if (ss_n) break;
            n_low++;
        end
        chk(n_low == 2 * total, {"R6 R10 select duration ", tag}, 64'(n_low), 64'(2 * total));
        chk(rec_tx.size() == total, {"R6 period count ", tag}, 64'(rec_tx.size()), 64'(total));
        if (rec_tx.size() == total) begin
            for (int k = 0; k < total; k++) begin
                chk((rec_tx[k] & exp_msk[k]) == exp_tx[k], {"R2 R3 R4 R5 lane value ", tag},
                    64'(rec_tx[k] & exp_msk[k]), 64'(exp_tx[k]));
                chk(rec_oe[k] == exp_oe[k], {"R7 R8 output enable ", tag},
                    64'(rec_oe[k]), 64'(exp_oe[k]));
            end
        end
        chk(sb_q.size() == 0, {"R9 R10 frames left ", tag}, 64'(sb_q.size()), 64'h0);
        repeat (4) @(negedge clk);
        chk(ss_n == 1'b1 && busy == 1'b0 && sclk == 1'b0, {"R12 idle after end ", tag},
            64'({ss_n, busy, sclk}), 64'h4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(ss_n == 1'b1, "R1 select in reset", 64'(ss_n), 64'h1);
        chk(sclk == 1'b0 && busy == 1'b0, "R1 clock and busy in reset", 64'({sclk, busy}), 64'h0);
        chk(oe_n == 8'hFF && rx_valid == 1'b0, "R1 enables in reset", 64'({oe_n, rx_valid}), 64'h1FE);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(ss_n == 1'b1 && busy == 1'b0, "R1 idle after reset", 64'({ss_n, busy}), 64'h2);

        run_xfer(2'b10, 2'b10, 2'd2, 4'd6, 5'd4, 8'd1, 16'h00EB, 60'h123456, 7, 0, "quad");
        run_xfer(2'b00, 2'b00, 2'd2, 4'd6, 5'd8, 8'd0, 16'h0003, 60'hABCDEF, 3, 0, "single");
        run_xfer(2'b01, 2'b00, 2'd3, 4'd8, 5'd2, 8'd2, 16'hC35A, 60'h89ABCDEF, 11, 0, "dual");
        run_xfer(2'b11, 2'b01, 2'd2, 4'd1, 5'd3, 8'd0, 16'h00B7, 60'hD, 5, 0, "octal pad");
        run_xfer(2'b11, 2'b10, 2'd1, 4'd15, 5'd0, 8'd1, 16'h0009,
                 60'hFEDCBA987654321, 9, 0, "octal wide");
        run_xfer(2'b10, 2'b10, 2'd0, 4'd0, 5'd5, 8'd3, 16'h0000, 60'h0, 2, 0, "R11 no command");
        run_xfer(2'b10, 2'b10, 2'd0, 4'd0, 5'd5, 8'd3, 16'h0000, 60'h0, 4, 1, "R12 start ignored");

        // R11: no instruction, no address and zero dummy periods is refused
        @(negedge clk);
        il = 2'd0; al = 4'd0; wc = 5'd0; fmt = 2'b10; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 5; k++) begin
            chk(busy == 1'b0 && ss_n == 1'b1, "R11 refused start", 64'({busy, ss_n}), 64'h1);
            @(negedge clk);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule